// File: doc/BRIEF.md
# Completion Ring Packet Gatherer

This block drains a circular completion ring. A producer writes entries into the ring, and the ring's size is a power of two. Each entry carries a status word, a buffer length, a request id and a hash. The block does not keep a fill count to know which entries are new. Instead, each entry carries a phase bit. The block keeps the phase value it expects and inverts it every time its head pointer wraps back to slot zero. An entry whose phase matches the expected value is new. An entry whose phase does not match is one the producer has not yet rewritten.

A poll request starts a walk from the current head. The block reads one slot at a time through a synchronous read port with one cycle of latency. It reports every consumed entry on a per-entry output and stops at the first entry that carries the end-of-packet flag. A packet can arrive split across several polls. In that case the entries consumed so far are remembered, and the packet is reported once the closing entry appears.

For each closed packet the block reports:
- the index of the packet's first slot;
- its total entry count;
- the protocol, checksum-error, fragment and hash values of its final entry.

Each good packet also advances a completion pointer for the companion submission queue. A packet longer than the configured buffer limit is flagged as an error instead of being reported.

Top module: `cring_gather`

## Requirements
- R1: Each read request presents the slot equal to the head count modulo DEPTH. Consecutive consumed entries come from consecutive slots, wrapping from DEPTH-1 to 0.
- R2: An entry is accepted only if its phase bit (status bit 14) equals the expected phase. A non-matching entry ends the poll, produces no entry output and no packet, and does not move the head.
- R3: The expected phase is 1 after reset. It inverts when the entry in slot DEPTH-1 is consumed, so after a wrap only entries with phase 0 are accepted, until the next wrap.
- R4: Within one poll, entries are consumed in slot order until an entry whose last flag (status bit 13) is set. Each consumed entry pulses `ent_vld_o` for one cycle with its slot, length and request id.
- R5: If a poll ends before a last flag, no packet is reported. The entries consumed so far count toward the packet that a later poll closes.
- R6: When a packet closes, `pkt_vld_o` pulses with the first slot of the packet and its total entry count, counted across all polls. The next packet starts at the slot after the closing entry.
- R7: If the total count exceeds `max_bufs_i`, `pkt_err_o` pulses instead of `pkt_vld_o`. The completion pointer and the final-entry flags stay unchanged, and the next packet still starts after the closing entry.
- R8: The final-entry outputs are updated from the closing entry of each good packet only. The status fields are: l3 protocol in bits 4:0, l4 protocol in bits 9:5, l3 checksum error in bit 10, l4 checksum error in bit 11, fragment in bit 12. The hash is updated from the same entry.
- R9: `sq_comp_o` increases by the entry count of every good packet, in the same cycle that `pkt_vld_o` is high.
- R10: After reset the block is idle with no strobes, no read request, and a zero completion pointer. The head is zero, and the first packet starts at slot 0.
- R11: At most one read is outstanding. `rd_req_o` is never high in two consecutive cycles, and data is taken the cycle after the request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| poll_i | input | 1 | Start a poll (ignored while busy) |
| max_bufs_i | input | CNT_W | Largest allowed entry count per packet |
| rd_req_o | output | 1 | Ring read request |
| rd_idx_o | output | IDX_W | Ring slot to read |
| rd_status_i | input | 15 | Status word of the slot, valid the cycle after the request |
| rd_len_i | input | LEN_W | Buffer length of the slot |
| rd_rid_i | input | RID_W | Request id of the slot |
| rd_hash_i | input | 32 | Hash of the slot |
| busy_o | output | 1 | Poll in progress |
| done_o | output | 1 | One-cycle pulse when a poll ends |
| ent_vld_o | output | 1 | Entry consumed |
| ent_idx_o | output | IDX_W | Slot of the consumed entry |
| ent_len_o | output | LEN_W | Length of the consumed entry |
| ent_rid_o | output | RID_W | Request id of the consumed entry |
| pkt_vld_o | output | 1 | Packet complete |
| pkt_err_o | output | 1 | Packet over the buffer limit |
| pkt_first_o | output | IDX_W | First slot of the packet |
| pkt_cnt_o | output | CNT_W | Entry count of the packet |
| l3_proto_o | output | 5 | L3 protocol of the final entry |
| l4_proto_o | output | 5 | L4 protocol of the final entry |
| l3_csum_err_o | output | 1 | L3 checksum error of the final entry |
| l4_csum_err_o | output | 1 | L4 checksum error of the final entry |
| frag_o | output | 1 | Fragment flag of the final entry |
| hash_o | output | 32 | Hash of the final entry |
| sq_comp_o | output | HEAD_W | Submission-queue completion pointer |

## Verification
A wrong expected phase shows up on the very next poll. The stale entry is accepted and appears on `ent_vld_o`, or the fresh entry is refused and the poll ends with no entry output. This is most visible just after the ring wraps, where an old phase-1 entry must now be refused. A lost partial count or a wrong start slot shows up only when the later closing poll pulses `pkt_vld_o` with the wrong first slot or count. An error packet that leaked into state would show one packet later, as a moved `sq_comp_o` or flags that changed when they should have held.

// File: rtl/cring_pkg.sv
package cring_pkg;
  localparam int STAT_W = 15;

  // bit 14 phase, 13 last, 12 frag, 11 l4 err, 10 l3 err, 9:5 l4, 4:0 l3
  typedef struct packed {
    logic       phase;
    logic       last;
    logic       frag;
    logic       l4_err;
    logic       l3_err;
    logic [4:0] l4_proto;
    logic [4:0] l3_proto;
  } cstat_t;

  typedef enum logic [1:0] {ST_IDLE, ST_READ, ST_EVAL} st_e;
endpackage

// File: rtl/cring_ptr.sv
module cring_ptr #(
  parameter int DEPTH = 8,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             adv_i,
  output logic [IDX_W-1:0] slot_o,
  output logic [IDX_W-1:0] slot_nxt_o,
  output logic             phase_o
);
  logic [IDX_W-1:0] head_q;
  logic             phase_q;

  assign slot_o     = head_q;
  assign slot_nxt_o = head_q + IDX_W'(1);
  assign phase_o    = phase_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      head_q  <= '0;
      phase_q <= 1'b1;
    end else if (adv_i) begin
      head_q <= slot_nxt_o;
      if (slot_nxt_o == '0) phase_q <= ~phase_q;
    end
  end

  p_phase_wrap_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (adv_i && slot_o == IDX_W'(DEPTH-1)) |=> (phase_o != $past(phase_o)));
  p_phase_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (adv_i && slot_o != IDX_W'(DEPTH-1)) |=> $stable(phase_o));
  p_head_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !adv_i |=> $stable(slot_o));
endmodule

// File: rtl/cring_acc.sv
module cring_acc #(
  parameter int IDX_W  = 3,
  parameter int CNT_W  = 16,
  parameter int HEAD_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              adv_i,
  input  logic              close_i,
  input  logic              stop_i,
  input  logic [CNT_W-1:0]  max_i,
  input  logic [IDX_W-1:0]  next_slot_i,
  output logic              fits_o,
  output logic              pkt_vld_o,
  output logic              err_o,
  output logic [IDX_W-1:0]  first_o,
  output logic [CNT_W-1:0]  cnt_o,
  output logic [HEAD_W-1:0] sq_o
);
  logic [CNT_W-1:0]  carry_q, run_q, total;
  logic [IDX_W-1:0]  start_q;

  assign total  = carry_q + run_q + CNT_W'(1);
  assign fits_o = total <= max_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      carry_q   <= '0;
      run_q     <= '0;
      start_q   <= '0;
      pkt_vld_o <= 1'b0;
      err_o     <= 1'b0;
      first_o   <= '0;
      cnt_o     <= '0;
      sq_o      <= '0;
    end else begin
      pkt_vld_o <= 1'b0;
      err_o     <= 1'b0;
      if (stop_i) begin
        carry_q <= carry_q + run_q;
        run_q   <= '0;
      end else if (close_i) begin
        carry_q <= '0;
        run_q   <= '0;
        start_q <= next_slot_i;
        first_o <= start_q;
        cnt_o   <= total;
        if (fits_o) begin
          pkt_vld_o <= 1'b1;
          sq_o      <= sq_o + HEAD_W'(total);
        end else begin
          err_o <= 1'b1;
        end
      end else if (adv_i) begin
        run_q <= run_q + CNT_W'(1);
      end
    end
  end

  p_sq_step_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pkt_vld_o |-> (sq_o == $past(sq_o) + HEAD_W'(cnt_o)));
  p_err_sq_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> $stable(sq_o));
  p_err_over_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> (cnt_o > $past(max_i)));
endmodule

// File: rtl/cring_gather.sv
module cring_gather
  import cring_pkg::*;
#(
  parameter int DEPTH  = 8,
  parameter int CNT_W  = 16,
  parameter int HEAD_W = 16,
  parameter int LEN_W  = 16,
  parameter int RID_W  = 16,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              poll_i,
  input  logic [CNT_W-1:0]  max_bufs_i,
  output logic              rd_req_o,
  output logic [IDX_W-1:0]  rd_idx_o,
  input  logic [STAT_W-1:0] rd_status_i,
  input  logic [LEN_W-1:0]  rd_len_i,
  input  logic [RID_W-1:0]  rd_rid_i,
  input  logic [31:0]       rd_hash_i,
  output logic              busy_o,
  output logic              done_o,
  output logic              ent_vld_o,
  output logic [IDX_W-1:0]  ent_idx_o,
  output logic [LEN_W-1:0]  ent_len_o,
  output logic [RID_W-1:0]  ent_rid_o,
  output logic              pkt_vld_o,
  output logic              pkt_err_o,
  output logic [IDX_W-1:0]  pkt_first_o,
  output logic [CNT_W-1:0]  pkt_cnt_o,
  output logic [4:0]        l3_proto_o,
  output logic [4:0]        l4_proto_o,
  output logic              l3_csum_err_o,
  output logic              l4_csum_err_o,
  output logic              frag_o,
  output logic [31:0]       hash_o,
  output logic [HEAD_W-1:0] sq_comp_o
);
  st_e              st_q, st_d;
  cstat_t           stat;
  logic             hit, adv, close, stop, fits, exp_phase;
  logic [IDX_W-1:0] slot, slot_nxt;

  assign stat  = cstat_t'(rd_status_i);
  assign hit   = (st_q == ST_EVAL) && (stat.phase == exp_phase);
  assign adv   = hit;
  assign close = hit && stat.last;
  assign stop  = (st_q == ST_EVAL) && !hit;

  assign rd_req_o = (st_q == ST_READ);
  assign rd_idx_o = slot;
  assign busy_o   = (st_q != ST_IDLE);

  cring_ptr #(.DEPTH(DEPTH)) u_ptr (
    .clk_i, .rst_ni, .adv_i(adv),
    .slot_o(slot), .slot_nxt_o(slot_nxt), .phase_o(exp_phase)
  );

  cring_acc #(.IDX_W(IDX_W), .CNT_W(CNT_W), .HEAD_W(HEAD_W)) u_acc (
    .clk_i, .rst_ni,
    .adv_i(adv), .close_i(close), .stop_i(stop),
    .max_i(max_bufs_i), .next_slot_i(slot_nxt),
    .fits_o(fits), .pkt_vld_o(pkt_vld_o), .err_o(pkt_err_o),
    .first_o(pkt_first_o), .cnt_o(pkt_cnt_o), .sq_o(sq_comp_o)
  );

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_IDLE: if (poll_i) st_d = ST_READ;
      ST_READ: st_d = ST_EVAL;
      ST_EVAL: st_d = (hit && !stat.last) ? ST_READ : ST_IDLE;
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q      <= ST_IDLE;
      done_o    <= 1'b0;
      ent_vld_o <= 1'b0;
      ent_idx_o <= '0;
      ent_len_o <= '0;
      ent_rid_o <= '0;
    end else begin
      st_q      <= st_d;
      done_o    <= (st_q == ST_EVAL) && (st_d == ST_IDLE);
      ent_vld_o <= adv;
      if (adv) begin
        ent_idx_o <= slot;
        ent_len_o <= rd_len_i;
        ent_rid_o <= rd_rid_i;
      end
    end
  end

  // final-entry flags, good packets only
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      l3_proto_o    <= '0;
      l4_proto_o    <= '0;
      l3_csum_err_o <= 1'b0;
      l4_csum_err_o <= 1'b0;
      frag_o        <= 1'b0;
      hash_o        <= '0;
    end else if (close && fits) begin
      l3_proto_o    <= stat.l3_proto;
      l4_proto_o    <= stat.l4_proto;
      l3_csum_err_o <= stat.l3_err;
      l4_csum_err_o <= stat.l4_err;
      frag_o        <= stat.frag;
      hash_o        <= rd_hash_i;
    end
  end

  p_one_rd_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_req_o |=> !rd_req_o);
  p_excl_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(pkt_vld_o && pkt_err_o));
  p_flags_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(pkt_vld_o) && !pkt_vld_o |-> $stable(hash_o));
  p_ent_follow_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ent_vld_o |-> $past(st_q == ST_EVAL));
endmodule

// File: tb/cring_gather_tb.sv
`timescale 1ns/1ps
module cring_gather_tb;
  localparam int D = 8;
  localparam int IW = $clog2(D);

  logic clk = 1'b0, rst_n = 1'b0, poll = 1'b0;
  logic [15:0] max_bufs = 16'd8;
  logic rd_req;
  logic [IW-1:0] rd_idx;
  logic [14:0] r_stat;
  logic [15:0] r_len, r_rid;
  logic [31:0] r_hash;
  logic busy, done, ent_vld, pkt_vld, pkt_err;
  logic [IW-1:0] ent_idx, pkt_first;
  logic [15:0] ent_len, ent_rid, pkt_cnt, sq;
  logic [4:0] l3, l4;
  logic l3e, l4e, frag;
  logic [31:0] hash;

  logic [14:0] m_stat [D];
  logic [15:0] m_len [D], m_rid [D];
  logic [31:0] m_hash [D];

  int errors = 0, checks = 0;
  int n_ent = 0, n_pkt = 0, n_err = 0, n_dbl = 0;
  int s_idx [16];
  int s_len [16];
  logic prev_rd = 1'b0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  cring_gather #(.DEPTH(D)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .poll_i(poll), .max_bufs_i(max_bufs),
    .rd_req_o(rd_req), .rd_idx_o(rd_idx), .rd_status_i(r_stat),
    .rd_len_i(r_len), .rd_rid_i(r_rid), .rd_hash_i(r_hash),
    .busy_o(busy), .done_o(done), .ent_vld_o(ent_vld), .ent_idx_o(ent_idx),
    .ent_len_o(ent_len), .ent_rid_o(ent_rid), .pkt_vld_o(pkt_vld),
    .pkt_err_o(pkt_err), .pkt_first_o(pkt_first), .pkt_cnt_o(pkt_cnt),
    .l3_proto_o(l3), .l4_proto_o(l4), .l3_csum_err_o(l3e),
    .l4_csum_err_o(l4e), .frag_o(frag), .hash_o(hash), .sq_comp_o(sq)
  );

  always @(posedge clk) if (rd_req) begin
    r_stat <= m_stat[rd_idx];
    r_len  <= m_len[rd_idx];
    r_rid  <= m_rid[rd_idx];
    r_hash <= m_hash[rd_idx];
  end

  always @(negedge clk) begin
    if (rst_n) begin
      if (ent_vld && n_ent < 16) begin
        s_idx[n_ent] = int'(ent_idx);
        s_len[n_ent] = int'(ent_len);
      end
      if (ent_vld) n_ent++;
      if (pkt_vld) n_pkt++;
      if (pkt_err) n_err++;
      if (rd_req && prev_rd) n_dbl++;
      prev_rd = rd_req;
    end
  end

  function automatic logic [14:0] mk(logic ph, logic last, logic fr, logic e4,
                                     logic e3, logic [4:0] p4, logic [4:0] p3);
    return {ph, last, fr, e4, e3, p4, p3};
  endfunction

  task automatic put(int s, logic [14:0] st, int len, int rid, logic [31:0] h);
    m_stat[s] = st; m_len[s] = 16'(len); m_rid[s] = 16'(rid); m_hash[s] = h;
  endtask

  task automatic chk(string tag, longint act, longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic do_poll();
    @(negedge clk);
    n_ent = 0; n_pkt = 0; n_err = 0;
    poll = 1'b1;
    @(negedge clk);
    poll = 1'b0;
    for (int i = 0; i < 60; i++) begin
      if (done) break;
      @(negedge clk);
    end
    chk("poll ends (done_o)", done, 1);
    @(negedge clk);
  endtask

  task automatic t_reset();
    chk("R10 busy", busy, 0);
    chk("R10 pkt_vld", pkt_vld, 0);
    chk("R10 rd_req", rd_req, 0);
    chk("R10 sq_comp", sq, 0);
    chk("R10 rd_idx", rd_idx, 0);
  endtask

  task automatic t_empty();
    do_poll();
    chk("R2 stale no entry", n_ent, 0);
    chk("R2 stale no packet", n_pkt, 0);
    chk("R2 head kept", rd_idx, 0);
  endtask

  task automatic t_single();
    put(0, mk(1, 1, 0, 1, 0, 5'd5, 5'd3), 100, 7, 32'hAAAA0001);
    do_poll();
    chk("R3 phase1 accepted", n_ent, 1);
    chk("R6 pkt count", n_pkt, 1);
    chk("R6 first", pkt_first, 0);
    chk("R6 cnt", pkt_cnt, 1);
    chk("R4 ent len", s_len[0], 100);
    chk("R4 ent rid", ent_rid, 7);
    chk("R8 l3", l3, 3);
    chk("R8 l4", l4, 5);
    chk("R8 l4 err", l4e, 1);
    chk("R9 sq", sq, 1);
  endtask

  task automatic t_multi();
    put(1, mk(1, 0, 0, 0, 1, 5'd1, 5'd1), 201, 11, 32'h1);
    put(2, mk(1, 0, 0, 1, 1, 5'd1, 5'd1), 202, 12, 32'h2);
    put(3, mk(1, 1, 1, 0, 0, 5'd2, 5'd4), 203, 13, 32'hBBBB0003);
    do_poll();
    chk("R4 three entries", n_ent, 3);
    chk("R1 second slot", s_idx[1], 2);
    chk("R4 second len", s_len[1], 202);
    chk("R6 first", pkt_first, 1);
    chk("R6 cnt", pkt_cnt, 3);
    chk("R8 l3 from last", l3, 4);
    chk("R8 l3 err from last", l3e, 0);
    chk("R8 frag", frag, 1);
    chk("R8 hash", hash, 32'hBBBB0003);
    chk("R9 sq", sq, 4);
  endtask

  task automatic t_partial();
    put(4, mk(1, 0, 0, 0, 0, 5'd0, 5'd2), 204, 14, 32'h4);
    put(5, mk(1, 0, 0, 0, 0, 5'd0, 5'd2), 205, 15, 32'h5);
    put(6, mk(0, 1, 0, 0, 0, 5'd0, 5'd2), 206, 16, 32'h6);
    do_poll();
    chk("R5 partial entries", n_ent, 2);
    chk("R5 no packet", n_pkt, 0);
    chk("R5 sq kept", sq, 4);
    put(6, mk(1, 1, 0, 0, 0, 5'd3, 5'd7), 206, 16, 32'hCCCC0006);
    do_poll();
    chk("R5 closing entry", n_ent, 1);
    chk("R5 pkt", n_pkt, 1);
    chk("R5 first carried", pkt_first, 4);
    chk("R5 cnt carried", pkt_cnt, 3);
    chk("R9 sq", sq, 7);
  endtask

  task automatic t_wrap();
    put(7, mk(1, 0, 0, 0, 0, 5'd0, 5'd0), 207, 17, 32'h7);
    put(0, mk(0, 1, 0, 0, 0, 5'd1, 5'd6), 300, 20, 32'hDDDD0000);
    do_poll();
    chk("R3 wrap entries", n_ent, 2);
    chk("R1 wrap order", s_idx[1], 0);
    chk("R6 wrap first", pkt_first, 7);
    chk("R6 wrap cnt", pkt_cnt, 2);
    chk("R8 l3 wrap", l3, 6);
    chk("R9 sq", sq, 9);
    do_poll();
    chk("R3 old phase refused", n_ent, 0);
    chk("R3 no packet", n_pkt, 0);
  endtask

  task automatic t_err();
    max_bufs = 16'd2;
    put(1, mk(0, 0, 0, 0, 0, 5'd0, 5'd9), 301, 21, 32'h11);
    put(2, mk(0, 0, 0, 0, 0, 5'd0, 5'd9), 302, 22, 32'h12);
    put(3, mk(0, 1, 0, 0, 0, 5'd0, 5'd9), 303, 23, 32'h13);
    do_poll();
    chk("R7 err pulse", n_err, 1);
    chk("R7 no packet", n_pkt, 0);
    chk("R7 sq kept", sq, 9);
    chk("R7 flags kept", l3, 6);
    chk("R7 hash kept", hash, 32'hDDDD0000);
    put(4, mk(0, 1, 0, 0, 0, 5'd0, 5'd8), 304, 24, 32'h14);
    do_poll();
    chk("R7 next pkt", n_pkt, 1);
    chk("R7 start moved", pkt_first, 4);
    chk("R7 next cnt", pkt_cnt, 1);
    chk("R9 sq", sq, 10);
    chk("R11 no back-to-back reads", n_dbl, 0);
  endtask

  initial begin
    for (int i = 0; i < D; i++) put(i, 15'd0, 0, 0, 32'h0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_empty();
    t_single();
    t_multi();
    t_partial();
    t_wrap();
    t_err();
    if (!finished) begin
      finished = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++; errors++;
      $display("FAIL watchdog: actual=expired expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule